// File: doc/BRIEF.md
# Interleaved Peak-Current PWM with Trip Capture

This block produces gate drive for a two-leg interleaved totem-pole power stage under peak current control. One up-counting time base sets the switching period. Each high-frequency leg starts its conduction interval at its own period start and ends it when its current comparator trips. The second leg runs half a period behind the first. When a trip is accepted, the block stores that leg's phase count. Software or a downstream predictor can then derive the real on-time without measuring any current.

The grid polarity input chooses the switches that work. On the positive half-wave the low-frequency leg's lower switch is held on and each fast leg switches its lower device. On the negative half-wave the roles of the upper and lower devices swap. An optional mode drives the idle device of each fast leg as a synchronous rectifier. A programmable dead time delays every gate's turn-on. A wrap pulse and a per-leg trip pulse mark the instants a downstream computation needs.

Top module: `ileave_pktrip_pwm`

## Requirements
- R1: The time base counts 0,1,…,`period` and then returns to 0, so one period lasts `period`+1 clocks. `zero_evt` is high for exactly the single clock in which the count is 0 after each return.
- R2: A leg's raw drive turns on at its phase 0. A comparator input passes two synchroniser flops. When the synchronised trip is seen during phase p < `period`, the drive ends after that clock and the leg's on-time output becomes p. The drive was therefore on for p+1 clocks.
- R3: Leg B's phase equals leg A's count shifted by floor((`period`+1)/2), modulo `period`+1. Its drive rises exactly that many clocks after leg A's, and its capture uses its own phase.
- R4: If no trip is accepted by phase `period` (a trip seen at phase `period` also counts as none), the drive stays on through the boundary. The capture becomes `period` and no trip pulse occurs.
- R5: A leg accepts at most one trip per period. Further trip activity before its next phase 0 changes neither its drive, its capture nor its trip pulse.
- R6: Polarity positive (`grid_pos`=1): `gate_lf_lo` on, `gate_lf_hi` off, each leg's lower gate carries the raw drive. Polarity negative: `gate_lf_hi` on, `gate_lf_lo` off, each leg's upper gate carries the raw drive.
- R7: With `sync_rect`=1, each leg's idle gate is requested whenever the raw drive is off. With `sync_rect`=0 the idle gate stays off.
- R8: Every gate turns on `dead_time` clocks after its request rises and turns off in the same clock as its request falls. The two gates of one leg are never on together.
- R9: `grid_pos` is sampled only in the clock where the count equals `period`. Changes at any other time leave the gates unchanged until the next wrap.
- R10: During reset and until the first wrap all gates are off. Both captures are 0 and all event pulses are low.
- R11: A leg's trip pulse is high for exactly one clock, the clock right after the trip was accepted, and its new capture is visible in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | time-base clock |
| rst_n | input | 1 | active-low synchronous reset |
| period | input | CNT_W | terminal count of the time base |
| dead_time | input | DT_W | turn-on delay of every gate, in clocks |
| grid_pos | input | 1 | 1 = positive grid half-wave |
| sync_rect | input | 1 | 1 = drive idle device complementary |
| trip_a | input | 1 | asynchronous comparator trip, leg A |
| trip_b | input | 1 | asynchronous comparator trip, leg B |
| gate_a_hi | output | 1 | leg A upper gate |
| gate_a_lo | output | 1 | leg A lower gate |
| gate_b_hi | output | 1 | leg B upper gate |
| gate_b_lo | output | 1 | leg B lower gate |
| gate_lf_hi | output | 1 | low-frequency leg upper gate |
| gate_lf_lo | output | 1 | low-frequency leg lower gate |
| ontime_a | output | CNT_W | captured phase at last accepted trip, leg A |
| ontime_b | output | CNT_W | captured phase at last accepted trip, leg B |
| zero_evt | output | 1 | wrap pulse |
| trip_evt_a | output | 1 | trip pulse, leg A |
| trip_evt_b | output | 1 | trip pulse, leg B |

## Verification
The bench builds the block with an 8-bit counter, a 4-bit dead time and a period register of 19. A whole period is then 20 clocks and leg B's offset is 10. The bench records every gate and pulse cycle by cycle in each period. This covers the trip capture at chosen phases, the untripped carry-over across a boundary, a polarity change in mid-period, and a 3-clock dead time with both gates of a leg visibly off.

// File: rtl/ileave_pktrip_pwm.sv
module ileave_pktrip_pwm #(
  parameter int CNT_W = 10,
  parameter int DT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic [DT_W-1:0]  dead_time,
  input  logic             grid_pos,
  input  logic             sync_rect,
  input  logic             trip_a,
  input  logic             trip_b,
  output logic             gate_a_hi,
  output logic             gate_a_lo,
  output logic             gate_b_hi,
  output logic             gate_b_lo,
  output logic             gate_lf_hi,
  output logic             gate_lf_lo,
  output logic [CNT_W-1:0] ontime_a,
  output logic [CNT_W-1:0] ontime_b,
  output logic             zero_evt,
  output logic             trip_evt_a,
  output logic             trip_evt_b
);
  localparam int W1 = CNT_W + 1;
  localparam int NGATE = 6;

  typedef enum logic [1:0] {POL_IDLE, POL_POS, POL_NEG} pol_t;

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [W1-1:0]    span, half;
  logic [CNT_W-1:0] phase [2];
  logic [1:0]       trip_in, raw, tevt;
  logic [CNT_W-1:0] cap [2];
  logic [NGATE-1:0] req, gate;
  pol_t             pol_q;

  assign wrap = (cnt >= period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      zero_evt <= 1'b0;
      pol_q    <= POL_IDLE;
    end else begin
      cnt      <= wrap ? '0 : cnt + 1'b1;
      zero_evt <= wrap;
      if (wrap) pol_q <= grid_pos ? POL_POS : POL_NEG;
    end
  end

  assign span     = {1'b0, period} + 1'b1;
  assign half     = span >> 1;
  assign phase[0] = cnt;
  assign phase[1] = ({1'b0, cnt} >= half) ? CNT_W'({1'b0, cnt} - half)
                                          : CNT_W'({1'b0, cnt} + span - half);
  assign trip_in  = {trip_b, trip_a};

  for (genvar g = 0; g < 2; g++) begin : g_leg
    logic [1:0] sy;
    logic       tripped;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sy      <= '0;
        tripped <= 1'b1;
        cap[g]  <= '0;
        tevt[g] <= 1'b0;
      end else begin
        sy      <= {sy[0], trip_in[g]};
        tevt[g] <= 1'b0;
        if (phase[g] >= period) begin
          tripped <= 1'b0;
          if (!tripped) cap[g] <= period;
        end else if (!tripped && sy[1]) begin
          tripped <= 1'b1;
          cap[g]  <= phase[g];
          tevt[g] <= 1'b1;
        end
      end
    end

    assign raw[g] = !tripped;

    always_comb begin
      case (pol_q)
        POL_POS: begin
          req[2*g+1] = raw[g];
          req[2*g]   = sync_rect && !raw[g];
        end
        POL_NEG: begin
          req[2*g]   = raw[g];
          req[2*g+1] = sync_rect && !raw[g];
        end
        default: begin
          req[2*g]   = 1'b0;
          req[2*g+1] = 1'b0;
        end
      endcase
    end

    p_trip_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tevt[g] |=> !tevt[g]);
    p_trip_below_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tevt[g] |-> (cap[g] < period || $past(period) != period));
    p_pair_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate[2*g] && gate[2*g+1]));
  end

  assign req[4] = (pol_q == POL_NEG);
  assign req[5] = (pol_q == POL_POS);

  for (genvar k = 0; k < NGATE; k++) begin : g_dead
    logic [DT_W-1:0] dc;
    always_ff @(posedge clk) begin
      if (!rst_n || !req[k]) dc <= '0;
      else if (dc < dead_time) dc <= dc + 1'b1;
    end
    assign gate[k] = req[k] && (dc >= dead_time);
  end

  assign gate_a_hi  = gate[0];
  assign gate_a_lo  = gate[1];
  assign gate_b_hi  = gate[2];
  assign gate_b_lo  = gate[3];
  assign gate_lf_hi = gate[4];
  assign gate_lf_lo = gate[5];
  assign ontime_a   = cap[0];
  assign ontime_b   = cap[1];
  assign trip_evt_a = tevt[0];
  assign trip_evt_b = tevt[1];

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 0) |-> (cnt == $past(cnt) + 1'b1));
  p_pol_at_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 0) |-> $stable(pol_q));
  p_lf_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_lf_hi && gate_lf_lo));
endmodule

// File: tb/ileave_pktrip_pwm_bench.sv
module ileave_pktrip_pwm_bench;
  localparam int CLK_P = 10;
  localparam int CW = 8;
  localparam int DW = 4;
  localparam int PER = 19;
  localparam int NP = PER + 1;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] period = CW'(PER);
  logic [DW-1:0] dead_time = '0;
  logic grid_pos = 1, sync_rect = 0, trip_a = 0, trip_b = 0;
  logic gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo, gate_lf_hi, gate_lf_lo;
  logic [CW-1:0] ontime_a, ontime_b;
  logic zero_evt, trip_evt_a, trip_evt_b;

  int n_run = 0, n_fail = 0;
  logic [NP-1:0] s_ahi, s_alo, s_bhi, s_blo, s_lfhi, s_lflo, s_tea, s_teb;

  ileave_pktrip_pwm #(.CNT_W(CW), .DT_W(DW)) u_ileave_pktrip_pwm (
    .clk, .rst_n, .period, .dead_time, .grid_pos, .sync_rect, .trip_a, .trip_b,
    .gate_a_hi, .gate_a_lo, .gate_b_hi, .gate_b_lo, .gate_lf_hi, .gate_lf_lo,
    .ontime_a, .ontime_b, .zero_evt, .trip_evt_a, .trip_evt_b);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_zero();
    do @(negedge clk); while (!zero_evt);
  endtask

  task automatic run_period(input int a_at, input int a2_at, input int b_at,
                            input int pol_at, input logic pol_val);
    wait_zero();
    for (int i = 0; i < NP; i++) begin
      if (i != 0) @(negedge clk);
      s_ahi[i] = gate_a_hi; s_alo[i] = gate_a_lo;
      s_bhi[i] = gate_b_hi; s_blo[i] = gate_b_lo;
      s_lfhi[i] = gate_lf_hi; s_lflo[i] = gate_lf_lo;
      s_tea[i] = trip_evt_a; s_teb[i] = trip_evt_b;
      if (i == a_at || i == a2_at) trip_a = 1;
      if (i == a_at + 4 || i == a2_at + 4) trip_a = 0;
      if (i == b_at) trip_b = 1;
      if (i == b_at + 4) trip_b = 0;
      if (i == pol_at) grid_pos = pol_val;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R10 gates", int'({gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo, gate_lf_hi, gate_lf_lo}), 0);
    chk("R10 ontime", int'(ontime_a) + int'(ontime_b), 0);
    chk("R10 events", int'({zero_evt, trip_evt_a, trip_evt_b}), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R10 gates before first wrap", int'({gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo, gate_lf_hi, gate_lf_lo}), 0);
    run_period(-10, -10, -10, -10, 1'b1);
  endtask

  task automatic t_period();
    int n;
    int ones;
    wait_zero();
    n = 0;
    ones = 0;
    do begin @(negedge clk); n++; if (zero_evt) ones++; end while (!zero_evt);
    chk("R1 wrap spacing", n, NP);
    @(negedge clk);
    chk("R1 zero pulse width", int'(zero_evt), 0);
  endtask

  task automatic t_trip_capture();
    run_period(5, 12, -10, -10, 1'b1);
    chk("R2 ontime_a", int'(ontime_a), 7);
    chk("R2 lower gate on-cycles", $countones(s_alo), 8);
    chk("R2 off after capture", int'(s_alo[8]), 0);
    chk("R11 trip pulse position", int'(s_tea[8]), 1);
    chk("R5 one pulse per period", $countones(s_tea), 1);
    chk("R4 ontime_b untripped", int'(ontime_b), PER);
    chk("R4 no leg B pulse", $countones(s_teb), 0);
    chk("R6 lf lower held", $countones(s_lflo), NP);
    chk("R6 lf upper off", $countones(s_lfhi), 0);
    chk("R7 idle gate off without sync", $countones(s_ahi), 0);
  endtask

  task automatic t_leg_b();
    run_period(-10, -10, 12, -10, 1'b1);
    chk("R4 leg B carried over", int'(s_blo[9]), 1);
    chk("R3 leg B capture", int'(ontime_b), 4);
    chk("R3 leg B on-cycles", $countones(s_blo[NP-1:10]), 5);
    chk("R11 leg B pulse", int'(s_teb[15]), 1);
    run_period(-10, -10, -10, -10, 1'b1);
    chk("R3 leg B off first half", $countones(s_blo[9:0]), 0);
    chk("R3 leg B rises at half", int'(s_blo[10]), 1);
    chk("R3 leg A on at zero", int'(s_alo[0]), 1);
  endtask

  task automatic t_polarity();
    run_period(-10, -10, -10, 5, 1'b0);
    chk("R9 lf lower held after mid change", $countones(s_lflo), NP);
    chk("R9 lf upper still off", $countones(s_lfhi), 0);
    run_period(3, -10, -10, -10, 1'b0);
    chk("R6 neg lf upper held", $countones(s_lfhi), NP);
    chk("R6 neg lf lower off", $countones(s_lflo), 0);
    chk("R6 neg upper active on-cycles", $countones(s_ahi), 6);
    chk("R6 neg lower off", $countones(s_alo), 0);
    chk("R2 neg ontime_a", int'(ontime_a), 5);
  endtask

  task automatic t_dead();
    grid_pos = 1; sync_rect = 1; dead_time = 4'd3;
    run_period(4, -10, -10, -10, 1'b1);
    run_period(4, -10, -10, -10, 1'b1);
    chk("R2 ontime_a dt", int'(ontime_a), 6);
    chk("R8 lower delayed on-cycles", $countones(s_alo), 4);
    chk("R8 lower starts after dt", int'(s_alo[3:0]), 4'b1000);
    chk("R8 both off after fall", int'(s_alo[9:7]) + int'(s_ahi[9:7]), 0);
    chk("R8 both off after wrap", int'(s_ahi[2:0]), 0);
    chk("R7 complementary on", $countones(s_ahi), 10);
    chk("R7 complementary at 10", int'(s_ahi[10]), 1);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_period();
    t_trip_capture();
    t_leg_b();
    t_polarity();
    t_dead();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule